// File: doc/BRIEF.md
# 4:2:2 to 4:4:4 Chroma Interpolator with Sync Alignment

The block accepts a half-rate 4:2:2 YCbCr stream and rebuilds full 4:4:4 samples at the full clock rate. Luma arrives on one bus. The two colour-difference components share a second bus and alternate from sample to sample. Every incoming sample is held for two clocks. A sync level input starts a stream on its rising edge. That edge sets the two-clock sampling phase and decides which chroma slot is blue-difference. A low sync ends the stream.

For every incoming sample the block emits two output samples. The first is the original sample. Its absent chroma component is filled in as the rounded mean of the same component in the two neighbouring samples. The second is a midpoint sample. Its luma is the rounded mean of two consecutive lumas, and its chroma is the rounded mean of the two reconstructed chroma values on either side. At the start of a stream, a neighbour that precedes the first sample is replaced by the nearest available one.

Top module: `ci_interp422`

## Requirements
- R1: While reset is asserted and after it is released, out_valid is 0 and y_out, cb_out and cr_out are 0 until the first valid output.
- R2: Let T be the first rising clock edge at which sync is sampled high after being low. Sample k (k = 0, 1, ...) is captured at edge T+1+2k, and must be held on y_in/c_in for edges T+1+2k and T+2+2k. The original output for sample k carries y_out = Y(k).
- R3: The chroma of sample k is blue-difference (Cb) when k is even and red-difference (Cr) when k is odd. In the original output of an even sample, cb_out equals its own chroma. At an odd sample, cb_out = (Cb(k-1) + Cb(k+1) + 1) >> 1, computed with a 9-bit sum.
- R4: In the original output of an odd sample, cr_out equals its own chroma. At an even sample k > 0, cr_out = (Cr(k-1) + Cr(k+1) + 1) >> 1.
- R5: The midpoint output that follows sample k carries y_out = (Y(k) + Y(k+1) + 1) >> 1.
- R6: The midpoint output that follows sample k carries cb_out and cr_out equal to the rounded mean of the reconstructed 4:4:4 chroma of samples k and k+1.
- R7: For sample 0 the missing Cr(-1) is replaced by Cr(1), so cr_out = Cr(1).
- R8: The original output of sample k is registered at edge T+6+2k and the midpoint output at edge T+7+2k, with out_valid high for each. out_valid is low after edges T through T+5.
- R9: Let D be the first edge at which sync is sampled low during a stream. No sample is captured at D, the output registered at D is still valid, and out_valid is 0 from edge D+1 on.
- R10: Sync low for a single edge followed by high restarts alignment. No sample from before the restart influences any later output, so sample 0 of the new stream again uses the R7 replication.
- R11: While sync has not risen, y_in and c_in have no effect and out_valid stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all state on rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sync | input | 1 | Stream level; rising edge aligns sample phase and Cb/Cr parity |
| y_in | input | DW | Luma of the current 4:2:2 sample |
| c_in | input | DW | Multiplexed chroma of the current 4:2:2 sample |
| y_out | output | DW | Output luma |
| cb_out | output | DW | Output blue-difference chroma |
| cr_out | output | DW | Output red-difference chroma |
| out_valid | output | 1 | High when the output buses carry a sample |

## Verification
The bound checker watches the control timing on every cycle. It checks the six silent cycles after each sync rise, that valid never appears without sync two cycles earlier, that output continues once started while sync stays high, and that output stops one edge after the stream ends. The arithmetic cannot be shown by properties over the ports: Cb/Cr parity, rounding, midpoint averaging and start-of-stream replication. The bench's scenarios cover these by comparing every output component against means computed from the driven samples, including a restart that proves the old samples are flushed.

// File: rtl/ci_pkg.sv
package ci_pkg;
   // sampling phase of the two-clock input period
   typedef enum logic {
      PH_HOLD  = 1'b0,   // input sample settles, no capture
      PH_LATCH = 1'b1    // capture edge
   } phase_e;

   // which output sample the output register loads
   typedef enum logic {
      OS_ORIG = 1'b0,
      OS_MID  = 1'b1
   } osel_e;

   // number of captured samples needed before the first output
   localparam int unsigned FILL_SAMPLES = 3;
   // window length: previous, centre, next, next-next
   localparam int unsigned WIN_DEPTH    = 4;
endpackage

// File: rtl/ci_avg.sv
module ci_avg #(
   parameter int unsigned DW       = 8,
   parameter bit          ROUND_UP = 1'b1
) (
   input  logic [DW-1:0] a,
   input  logic [DW-1:0] b,
   output logic [DW-1:0] m
);
   localparam int unsigned SW = DW + 1;

   logic [SW-1:0] sum;

   generate
      if (ROUND_UP) begin : g_round
         assign sum = {1'b0, a} + {1'b0, b} + {{DW{1'b0}}, 1'b1};
      end else begin : g_trunc
         assign sum = {1'b0, a} + {1'b0, b};
      end
   endgenerate

   assign m = sum[SW-1:1];
endmodule

// File: rtl/ci_sync_ctrl.sv
module ci_sync_ctrl
   import ci_pkg::*;
#(
   parameter int unsigned FILL = FILL_SAMPLES
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sync,
   output logic take,
   output logic par,
   output logic emit,
   output logic pick_mid,
   output logic have_prev
);
   localparam int unsigned SAT   = FILL + 1;
   localparam int unsigned CNT_W = $clog2(SAT + 1);

   logic             sync_q;
   logic             active;
   phase_e           ph;
   logic [CNT_W-1:0] cnt;
   logic             rise;

   assign rise = sync & ~sync_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= 1'b0;
         active <= 1'b0;
         ph     <= PH_HOLD;
         cnt    <= '0;
         par    <= 1'b0;
      end else begin
         sync_q <= sync;
         if (rise) begin
            active <= 1'b1;
            ph     <= PH_LATCH;
            cnt    <= '0;
            par    <= 1'b0;
         end else if (!sync) begin
            active <= 1'b0;
            ph     <= PH_HOLD;
            cnt    <= '0;
         end else if (active) begin
            if (ph == PH_LATCH) begin
               ph  <= PH_HOLD;
               par <= ~par;
               if (cnt != CNT_W'(SAT)) cnt <= cnt + 1'b1;
            end else begin
               ph <= PH_LATCH;
            end
         end
      end
   end

   assign take      = active & sync & ~rise & (ph == PH_LATCH);
   assign emit      = active & (cnt >= CNT_W'(FILL));
   assign pick_mid  = (ph == PH_LATCH);
   assign have_prev = (cnt >= CNT_W'(SAT));
endmodule

// File: rtl/ci_window.sv
module ci_window #(
   parameter int unsigned DW    = 8,
   parameter int unsigned DEPTH = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          take,
   input  logic [DW-1:0] y_in,
   input  logic [DW-1:0] c_in,
   input  logic          par_in,
   output logic [DW-1:0] win_y [DEPTH],
   output logic [DW-1:0] win_c [DEPTH],
   output logic          win_p [DEPTH]
);
   genvar i;
   generate
      for (i = 0; i < DEPTH; i++) begin : g_tap
         if (i == 0) begin : g_head
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  win_y[0] <= '0;
                  win_c[0] <= '0;
                  win_p[0] <= 1'b0;
               end else if (take) begin
                  win_y[0] <= y_in;
                  win_c[0] <= c_in;
                  win_p[0] <= par_in;
               end
            end
         end else begin : g_body
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  win_y[i] <= '0;
                  win_c[i] <= '0;
                  win_p[i] <= 1'b0;
               end else if (take) begin
                  win_y[i] <= win_y[i-1];
                  win_c[i] <= win_c[i-1];
                  win_p[i] <= win_p[i-1];
               end
            end
         end
      end
   endgenerate
endmodule

// File: rtl/ci_recon.sv
module ci_recon #(
   parameter int unsigned DW       = 8,
   parameter bit          ROUND_UP = 1'b1
) (
   input  logic [DW-1:0] ctr_y,
   input  logic [DW-1:0] ctr_c,
   input  logic          ctr_odd,
   input  logic [DW-1:0] prev_c,
   input  logic [DW-1:0] next_c,
   input  logic          prev_ok,
   output logic [DW-1:0] y,
   output logic [DW-1:0] cb,
   output logic [DW-1:0] cr
);
   logic [DW-1:0] left_c;
   logic [DW-1:0] fill_c;

   // before the first sample the nearest neighbour stands in
   assign left_c = prev_ok ? prev_c : next_c;

   ci_avg #(.DW(DW), .ROUND_UP(ROUND_UP)) u_fill (
      .a (left_c),
      .b (next_c),
      .m (fill_c)
   );

   assign y  = ctr_y;
   assign cb = ctr_odd ? fill_c : ctr_c;
   assign cr = ctr_odd ? ctr_c  : fill_c;
endmodule

// File: rtl/ci_interp422.sv
module ci_interp422
   import ci_pkg::*;
#(
   parameter int unsigned DW       = 8,
   parameter bit          ROUND_UP = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sync,
   input  logic [DW-1:0] y_in,
   input  logic [DW-1:0] c_in,
   output logic [DW-1:0] y_out,
   output logic [DW-1:0] cb_out,
   output logic [DW-1:0] cr_out,
   output logic          out_valid
);
   localparam int unsigned DEPTH = WIN_DEPTH;
   // window slots: 0 newest ... 3 oldest
   localparam int unsigned S_NN  = 0;
   localparam int unsigned S_NX  = 1;
   localparam int unsigned S_CT  = 2;
   localparam int unsigned S_PV  = 3;

   generate
      if (DW < 2) begin : g_bad_dw
         $error("ci_interp422: DW must be at least 2");
      end
      if (DEPTH != FILL_SAMPLES + 1) begin : g_bad_depth
         $error("ci_interp422: window depth must exceed fill count by one");
      end
   endgenerate

   logic take, par, emit, pick_mid, have_prev;

   ci_sync_ctrl #(.FILL(FILL_SAMPLES)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .sync      (sync),
      .take      (take),
      .par       (par),
      .emit      (emit),
      .pick_mid  (pick_mid),
      .have_prev (have_prev)
   );

   logic [DW-1:0] win_y [DEPTH];
   logic [DW-1:0] win_c [DEPTH];
   logic          win_p [DEPTH];

   ci_window #(.DW(DW), .DEPTH(DEPTH)) u_win (
      .clk    (clk),
      .rst_n  (rst_n),
      .take   (take),
      .y_in   (y_in),
      .c_in   (c_in),
      .par_in (par),
      .win_y  (win_y),
      .win_c  (win_c),
      .win_p  (win_p)
   );

   // full sample at the centre slot
   logic [DW-1:0] a_y, a_cb, a_cr;
   ci_recon #(.DW(DW), .ROUND_UP(ROUND_UP)) u_rec_a (
      .ctr_y   (win_y[S_CT]),
      .ctr_c   (win_c[S_CT]),
      .ctr_odd (win_p[S_CT]),
      .prev_c  (win_c[S_PV]),
      .next_c  (win_c[S_NX]),
      .prev_ok (have_prev),
      .y       (a_y),
      .cb      (a_cb),
      .cr      (a_cr)
   );

   // full sample one step later, its left neighbour always present
   logic [DW-1:0] b_y, b_cb, b_cr;
   ci_recon #(.DW(DW), .ROUND_UP(ROUND_UP)) u_rec_b (
      .ctr_y   (win_y[S_NX]),
      .ctr_c   (win_c[S_NX]),
      .ctr_odd (win_p[S_NX]),
      .prev_c  (win_c[S_CT]),
      .next_c  (win_c[S_NN]),
      .prev_ok (1'b1),
      .y       (b_y),
      .cb      (b_cb),
      .cr      (b_cr)
   );

   logic [DW-1:0] m_y, m_cb, m_cr;
   ci_avg #(.DW(DW), .ROUND_UP(ROUND_UP)) u_mid_y  (.a(a_y),  .b(b_y),  .m(m_y));
   ci_avg #(.DW(DW), .ROUND_UP(ROUND_UP)) u_mid_cb (.a(a_cb), .b(b_cb), .m(m_cb));
   ci_avg #(.DW(DW), .ROUND_UP(ROUND_UP)) u_mid_cr (.a(a_cr), .b(b_cr), .m(m_cr));

   osel_e osel;
   assign osel = pick_mid ? OS_MID : OS_ORIG;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         y_out     <= '0;
         cb_out    <= '0;
         cr_out    <= '0;
      end else if (emit) begin
         out_valid <= 1'b1;
         if (osel == OS_MID) begin
            y_out  <= m_y;
            cb_out <= m_cb;
            cr_out <= m_cr;
         end else begin
            y_out  <= a_y;
            cb_out <= a_cb;
            cr_out <= a_cr;
         end
      end else begin
         out_valid <= 1'b0;
      end
   end
endmodule

// File: rtl/ci_interp422_chk.sv
module ci_interp422_chk (
   input logic clk,
   input logic rst_n,
   input logic sync,
   input logic out_valid
);
   // R8
   fill_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sync) |=> !out_valid ##1 !out_valid ##1 !out_valid
                      ##1 !out_valid ##1 !out_valid ##1 !out_valid);

   // R8
   steady_flow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && sync && $past(sync)) |=> out_valid);

   // R9
   stream_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sync && $past(!sync)) |=> !out_valid);

   // R11
   needs_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(sync, 2));
endmodule

bind ci_interp422 ci_interp422_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .sync      (sync),
   .out_valid (out_valid)
);

// File: tb/sim_ci_interp422.sv
`timescale 1ns/1ps
module sim_ci_interp422;
   localparam int DW = 8;
   localparam int NV = 10;
   // {luma, chroma} for sample k of the first stream
   localparam logic [15:0] VEC [NV] = '{
      {8'd10,  8'd100}, {8'd21,  8'd17},  {8'd250, 8'd201}, {8'd3,   8'd90},
      {8'd128, 8'd255}, {8'd127, 8'd0},   {8'd0,   8'd33},  {8'd255, 8'd34},
      {8'd64,  8'd180}, {8'd65,  8'd7}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          sync = 1'b0;
   logic [DW-1:0] y_in = '0, c_in = '0;
   logic [DW-1:0] y_out, cb_out, cr_out;
   logic          out_valid;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [7:0] sy [16];
   logic [7:0] sc [16];

   always #4 clk = ~clk;

   ci_interp422 #(.DW(DW), .ROUND_UP(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .sync(sync), .y_in(y_in), .c_in(c_in),
      .y_out(y_out), .cb_out(cb_out), .cr_out(cr_out), .out_valid(out_valid)
   );

   function automatic logic [7:0] av(input logic [7:0] a, input logic [7:0] b);
      logic [8:0] s;
      s = {1'b0, a} + {1'b0, b} + 9'd1;
      return s[8:1];
   endfunction

   function automatic logic [7:0] cbv(input int k);
      return (k % 2 == 0) ? sc[k] : av(sc[k-1], sc[k+1]);
   endfunction

   function automatic logic [7:0] crv(input int k);
      if (k % 2 == 1) return sc[k];
      if (k == 0) return sc[1];
      return av(sc[k-1], sc[k+1]);
   endfunction

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // one stream of m samples; sync low is driven for edge 2m+1
   task automatic run_stream(input int m, input bit tail, input bit restart);
      int last;
      last = tail ? 2*m + 2 : 2*m + 1;
      for (int e = 0; e <= last; e++) begin
         @(negedge clk);
         sync = (e <= 2*m);
         if (e >= 1 && e <= 2*m) begin
            y_in = sy[(e-1)/2];
            c_in = sc[(e-1)/2];
         end else begin
            y_in = 8'hEE;
            c_in = 8'h11;
         end
         @(posedge clk);
         #2;
         if (e < 6) begin
            chk(restart ? "R10 valid" : "R8 valid", {7'd0, out_valid}, 8'd0);
         end else if (e <= 2*m + 1) begin
            int k;
            k = (e - 6) / 2;
            chk(e == 2*m + 1 ? "R9 last valid" : "R8 valid", {7'd0, out_valid}, 8'd1);
            if (e % 2 == 0) begin
               chk("R2 y", y_out, sy[k]);
               chk("R3 cb", cb_out, cbv(k));
               if (k == 0) chk(restart ? "R10 cr" : "R7 cr", cr_out, crv(k));
               else        chk("R4 cr", cr_out, crv(k));
            end else begin
               chk("R5 y", y_out, av(sy[k], sy[k+1]));
               chk("R6 cb", cb_out, av(cbv(k), cbv(k+1)));
               chk("R6 cr", cr_out, av(crv(k), crv(k+1)));
            end
         end else begin
            chk("R9 valid", {7'd0, out_valid}, 8'd0);
         end
      end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #2;
      chk("R1 valid", {7'd0, out_valid}, 8'd0);
      chk("R1 y", y_out, 8'd0);
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      #2;
      chk("R1 cb", cb_out, 8'd0);
      chk("R1 cr", cr_out, 8'd0);

      // R11: data moves while sync stays low
      for (int i = 0; i < 12; i++) begin
         @(negedge clk);
         y_in = 8'(i * 29 + 3);
         c_in = 8'(i * 71 + 9);
         @(posedge clk);
         #2;
         chk("R11 valid", {7'd0, out_valid}, 8'd0);
      end

      // table-driven stream
      for (int k = 0; k < NV; k++) begin
         sy[k] = VEC[k][15:8];
         sc[k] = VEC[k][7:0];
      end
      run_stream(NV, 1'b1, 1'b0);

      // stream cut short by a one-edge sync drop, then restarted
      for (int k = 0; k < 8; k++) begin
         sy[k] = 8'(k * 53 + 7);
         sc[k] = 8'(k * 91 + 200);
      end
      run_stream(8, 1'b0, 1'b0);
      for (int k = 0; k < 8; k++) begin
         sy[k] = 8'(240 - k * 37);
         sc[k] = 8'(k * 45 + 13);
      end
      run_stream(8, 1'b1, 1'b1);

      // shortest stream that yields output
      sy[0] = 8'd255; sc[0] = 8'd1;
      sy[1] = 8'd0;   sc[1] = 8'd254;
      sy[2] = 8'd200; sc[2] = 8'd255;
      run_stream(3, 1'b1, 1'b0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule